// File: doc/BRIEF.md
# Calendar Time Counter With Update Cycle

This block keeps a wall-clock calendar (seconds, minutes, hours, day of week, day of month, month, two-digit year) behind a byte-wide address/data register port. A host writes and reads each field by address. A one-cycle tick from an external one-hertz prescaler starts an update cycle. A busy flag rises first. After a fixed lead time the whole calendar advances by one second with full carry through minutes, hours, days, months and years. The flag then stays high for a fixed settling window, falls, and a one-clock completion pulse goes to the interrupt logic.

Every field reads and writes as BCD or as plain binary, chosen by a control bit. Hours read and write in 24-hour form or in 12-hour form with a PM marker in bit 7. Internally the calendar is held in binary and converted at the port, so the format bits can be changed at any time without corrupting the stored time. A halt bit blocks update cycles so software can load a consistent time.

Top module: `rtc_calendar_core`

## Requirements
- R1: Field addresses are seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9. Control A is 10 (bits 6:0 read/write, bit 7 the busy flag) and control B is 11 (all 8 bits read/write). A value written to a field reads back unchanged in the same format. Read data is registered and appears one clock after the address. After reset the time is 00:00:00, day of week 1, day 1, month 1, year 0, and both control registers are 0.
- R2: Addresses 1, 3, 5 and 12 to 15 read as 0. Writes to them change no register.
- R3: A tick while idle raises the busy flag (port `uip_o` and bit 7 of address 10) on the next clock. The calendar changes exactly LEAD_CYCLES clocks after that. The flag stays high for LEAD_CYCLES + UPD_CYCLES clocks in total.
- R4: `upd_done_o` is high for exactly one clock, the clock right after the busy flag falls.
- R5: While bit 7 of control B is set, ticks start no cycle. Setting it during the lead time abandons the cycle with no advance and no completion pulse.
- R6: Bit 2 of control B clear means every field is BCD (tens in bits 7:4, units in bits 3:0). Set means plain binary. Writes are decoded and reads encoded with the current setting.
- R7: Bit 1 of control B set gives 24-hour hours (0 to 23). Clear gives 12-hour hours: value 12 for midnight and noon, 1 to 11 otherwise, with bit 7 = 1 for PM (hours 12 to 23).
- R8: An advance takes seconds and minutes from 59 to 0 with carry, and hours from 23 to 0 with carry into the day. In 12-hour form, 11 AM goes to 12 PM and 11 PM goes to 12 AM.
- R9: Day of week counts 1 to 7 and goes from 7 back to 1 on a day carry.
- R10: Day of month wraps to 1 after 31 (months 1, 3, 5, 7, 8, 10, 12), after 30 (months 4, 6, 9, 11), or after February's 29 when the year is divisible by 4 and 28 otherwise. Month goes from 12 to 1 and the year from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse from the one-hertz prescaler |
| addr_i | input | 4 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe for `wr_data_i` at `addr_i` |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data for the previous cycle's address |
| uip_o | output | 1 | Update-cycle busy flag |
| upd_done_o | output | 1 | One-clock pulse when an update cycle ends |

## Verification
Random times are loaded in all four combinations of number format and hour format, with extra weight on values that sit on a rollover. Each load is followed by one or two updates, and every field is read back. This separates plain increments from carries, and encoding faults from counting faults. Directed cases cover the year-end cascade, each month length, leap and non-leap February, and both 12-hour noon and midnight crossings. They also cover the lead-time count observed on the read port, a halt held across a tick, a halt set mid-lead, and writes to reserved addresses. Together these tell apart a wrong lead or settle count, a missing abort, and a leaking reserved decode.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int REG_ADDR_W = 4;
  localparam int REG_DATA_W = 8;

  localparam logic [3:0] ADR_SEC  = 4'd0;
  localparam logic [3:0] ADR_MIN  = 4'd2;
  localparam logic [3:0] ADR_HR   = 4'd4;
  localparam logic [3:0] ADR_DOW  = 4'd6;
  localparam logic [3:0] ADR_DOM  = 4'd7;
  localparam logic [3:0] ADR_MON  = 4'd8;
  localparam logic [3:0] ADR_YR   = 4'd9;
  localparam logic [3:0] ADR_CTLA = 4'd10;
  localparam logic [3:0] ADR_CTLB = 4'd11;

  localparam int CTLB_HALT = 7;
  localparam int CTLB_BIN  = 2;
  localparam int CTLB_H24  = 1;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LEAD, SEQ_BUSY} seq_state_e;

  // binary 0..99 -> packed decimal
  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  // packed decimal -> binary
  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    logic [7:0] acc;
    acc = {4'd0, b[3:0]} + ({4'd0, b[7:4]} * 8'd10);
    return acc[6:0];
  endfunction

  function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin_mode);
    return bin_mode ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_field(input logic [7:0] d, input logic bin_mode);
    return bin_mode ? d[6:0] : from_bcd(d);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] yr);
    logic [4:0] len;
    case (mon)
      4'd2:                    len = (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: len = 5'd30;
      default:                 len = 5'd31;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_cal_pkg::*;
#(
  parameter int LEAD_CYCLES = 8,
  parameter int UPD_CYCLES  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic halt_i,
  output logic busy_o,
  output logic adv_o,
  output logic done_o
);

  localparam int MAX_CNT = (LEAD_CYCLES > UPD_CYCLES) ? LEAD_CYCLES : UPD_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LEAD_LOAD = CNT_W'(LEAD_CYCLES - 1);
  localparam logic [CNT_W-1:0] UPD_LOAD  = CNT_W'(UPD_CYCLES - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (tick_i && !halt_i) begin
            state_q <= SEQ_LEAD;
            cnt_q   <= LEAD_LOAD;
          end
        end
        SEQ_LEAD: begin
          if (halt_i) begin
            state_q <= SEQ_IDLE;
          end else if (cnt_q == '0) begin
            state_q <= SEQ_BUSY;
            cnt_q   <= UPD_LOAD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SEQ_BUSY: begin
          if (cnt_q == '0) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);
  assign adv_o  = (state_q == SEQ_LEAD) && (cnt_q == '0) && !halt_i;
  assign done_o = done_q;

  // R4
  done_one_chk: assert property (@(posedge clk) disable iff (rst) done_q |=> !done_q);

  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> ($past(state_q) == SEQ_BUSY));

  // R5
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE) && halt_i |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/rtc_time_counters.sv
module rtc_time_counters
  import rtc_cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv_i,
  input  logic                  busy_i,
  input  logic                  wr_en_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [REG_DATA_W-1:0] wr_data_i,
  input  logic                  bin_i,
  input  logic                  h24_i,
  output logic [6:0]            sec_o,
  output logic [6:0]            min_o,
  output logic [4:0]            hr_o,
  output logic [2:0]            dow_o,
  output logic [4:0]            dom_o,
  output logic [3:0]            mon_o,
  output logic [6:0]            yr_o
);

  logic [6:0] sec_q, min_q, yr_q;
  logic [4:0] hr_q, dom_q;
  logic [2:0] dow_q;
  logic [3:0] mon_q;

  // next-second values with full carry chain
  logic       c_min, c_hr, c_day, c_mon, c_yr;
  logic [6:0] n_sec, n_min, n_yr;
  logic [4:0] n_hr, n_dom;
  logic [2:0] n_dow;
  logic [3:0] n_mon;

  always_comb begin
    c_min = (sec_q >= 7'd59);
    c_hr  = c_min && (min_q >= 7'd59);
    c_day = c_hr && (hr_q >= 5'd23);
    c_mon = c_day && (dom_q >= days_in_month(mon_q, yr_q));
    c_yr  = c_mon && (mon_q >= 4'd12);

    n_sec = c_min ? 7'd0 : sec_q + 7'd1;
    n_min = c_min ? ((min_q >= 7'd59) ? 7'd0 : min_q + 7'd1) : min_q;
    n_hr  = c_hr  ? ((hr_q >= 5'd23) ? 5'd0 : hr_q + 5'd1) : hr_q;
    n_dow = c_day ? ((dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1) : dow_q;
    n_dom = c_day ? (c_mon ? 5'd1 : dom_q + 5'd1) : dom_q;
    n_mon = c_mon ? (c_yr ? 4'd1 : mon_q + 4'd1) : mon_q;
    n_yr  = c_yr  ? ((yr_q >= 7'd99) ? 7'd0 : yr_q + 7'd1) : yr_q;
  end

  // host write decode
  logic [6:0] wr_val, wr_h12, wr_hr;

  always_comb begin
    wr_val = dec_field(wr_data_i, bin_i);
    wr_h12 = dec_field({1'b0, wr_data_i[6:0]}, bin_i);
    if (h24_i) begin
      wr_hr = wr_val;
    end else begin
      wr_hr = ((wr_h12 == 7'd12) ? 7'd0 : wr_h12) + (wr_data_i[7] ? 7'd12 : 7'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      dow_q <= 3'd1;
      dom_q <= 5'd1;
      mon_q <= 4'd1;
      yr_q  <= '0;
    end else begin
      if (adv_i) begin
        sec_q <= n_sec;
        min_q <= n_min;
        hr_q  <= n_hr;
        dow_q <= n_dow;
        dom_q <= n_dom;
        mon_q <= n_mon;
        yr_q  <= n_yr;
      end
      // a host write to a field takes priority over the advance
      if (wr_en_i) begin
        case (addr_i)
          ADR_SEC: sec_q <= wr_val;
          ADR_MIN: min_q <= wr_val;
          ADR_HR:  hr_q  <= wr_hr[4:0];
          ADR_DOW: dow_q <= wr_val[2:0];
          ADR_DOM: dom_q <= wr_val[4:0];
          ADR_MON: mon_q <= wr_val[3:0];
          ADR_YR:  yr_q  <= wr_val;
          default: ;
        endcase
      end
    end
  end

  assign sec_o = sec_q;
  assign min_o = min_q;
  assign hr_o  = hr_q;
  assign dow_o = dow_q;
  assign dom_o = dom_q;
  assign mon_o = mon_q;
  assign yr_o  = yr_q;

  // R3
  adv_in_busy_chk: assert property (@(posedge clk) disable iff (rst) adv_i |-> busy_i);

  // R8
  sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && !wr_en_i && (sec_q == 7'd59) |=> (sec_q == 7'd0));

  // R9
  dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && !wr_en_i && (dow_q == 3'd7) && (sec_q == 7'd59) && (min_q == 7'd59) && (hr_q == 5'd23)
    |=> (dow_q == 3'd1));

  // R10
  year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && !wr_en_i && (yr_q == 7'd99) && (mon_q == 4'd12) && (dom_q == 5'd31) &&
    (hr_q == 5'd23) && (min_q == 7'd59) && (sec_q == 7'd59)
    |=> (yr_q == 7'd0) && (mon_q == 4'd1) && (dom_q == 5'd1));

endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_cal_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  bin_i,
  input  logic                  h24_i,
  input  logic                  busy_i,
  input  logic [6:0]            ctla_i,
  input  logic [7:0]            ctlb_i,
  input  logic [6:0]            sec_i,
  input  logic [6:0]            min_i,
  input  logic [4:0]            hr_i,
  input  logic [2:0]            dow_i,
  input  logic [4:0]            dom_i,
  input  logic [3:0]            mon_i,
  input  logic [6:0]            yr_i,
  output logic [REG_DATA_W-1:0] rd_data_o
);

  logic [4:0] h12;
  logic [7:0] h12_enc;
  logic [7:0] hr_byte;
  logic [7:0] rd_next;
  logic [7:0] rd_q;

  always_comb begin
    if (hr_i == 5'd0)       h12 = 5'd12;
    else if (hr_i > 5'd12)  h12 = hr_i - 5'd12;
    else                    h12 = hr_i;
    h12_enc = enc_field({2'b00, h12}, bin_i);
    hr_byte = h24_i ? enc_field({2'b00, hr_i}, bin_i)
                    : {(hr_i >= 5'd12), h12_enc[6:0]};
  end

  always_comb begin
    case (addr_i)
      ADR_SEC:  rd_next = enc_field(sec_i, bin_i);
      ADR_MIN:  rd_next = enc_field(min_i, bin_i);
      ADR_HR:   rd_next = hr_byte;
      ADR_DOW:  rd_next = enc_field({4'd0, dow_i}, bin_i);
      ADR_DOM:  rd_next = enc_field({2'd0, dom_i}, bin_i);
      ADR_MON:  rd_next = enc_field({3'd0, mon_i}, bin_i);
      ADR_YR:   rd_next = enc_field(yr_i, bin_i);
      ADR_CTLA: rd_next = {busy_i, ctla_i};
      ADR_CTLB: rd_next = ctlb_i;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign rd_data_o = rd_q;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i == 4'd1) || (addr_i == 4'd3) || (addr_i == 4'd5) || (addr_i >= 4'd12)
    |=> (rd_q == 8'h00));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int LEAD_CYCLES = 8,
  parameter int UPD_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [3:0] addr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       uip_o,
  output logic       upd_done_o
);

  logic [6:0] ctla_q;
  logic [7:0] ctlb_q;
  logic       busy, adv, done;
  logic [6:0] sec, min, yr;
  logic [4:0] hr, dom;
  logic [2:0] dow;
  logic [3:0] mon;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_q <= '0;
      ctlb_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_CTLA) ctla_q <= wr_data_i[6:0];
      if (addr_i == ADR_CTLB) ctlb_q <= wr_data_i;
    end
  end

  rtc_update_seq #(
    .LEAD_CYCLES(LEAD_CYCLES),
    .UPD_CYCLES (UPD_CYCLES)
  ) u_seq (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick_i),
    .halt_i (ctlb_q[CTLB_HALT]),
    .busy_o (busy),
    .adv_o  (adv),
    .done_o (done)
  );

  rtc_time_counters u_cnt (
    .clk       (clk),
    .rst       (rst),
    .adv_i     (adv),
    .busy_i    (busy),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .bin_i     (ctlb_q[CTLB_BIN]),
    .h24_i     (ctlb_q[CTLB_H24]),
    .sec_o     (sec),
    .min_o     (min),
    .hr_o      (hr),
    .dow_o     (dow),
    .dom_o     (dom),
    .mon_o     (mon),
    .yr_o      (yr)
  );

  rtc_read_mux u_rd (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .bin_i     (ctlb_q[CTLB_BIN]),
    .h24_i     (ctlb_q[CTLB_H24]),
    .busy_i    (busy),
    .ctla_i    (ctla_q),
    .ctlb_i    (ctlb_q),
    .sec_i     (sec),
    .min_i     (min),
    .hr_i      (hr),
    .dow_i     (dow),
    .dom_i     (dom),
    .mon_i     (mon),
    .yr_i      (yr),
    .rd_data_o (rd_data_o)
  );

  assign uip_o      = busy;
  assign upd_done_o = done;

  // R4
  done_flag_low_chk: assert property (@(posedge clk) disable iff (rst) upd_done_o |-> !uip_o);

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 8;
  localparam int UPD  = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] addr = 4'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       uip;
  logic       upd_done;

  int nvec = 0;
  int nerr = 0;

  // bench model of the calendar, binary
  int ms, mm, mh, mw, md, mo, my;
  bit fbin, fh24;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_calendar_core #(.LEAD_CYCLES(LEAD), .UPD_CYCLES(UPD)) i_rtc_calendar_core (
    .clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .uip_o(uip), .upd_done_o(upd_done)
  );

  function automatic int b_enc(int v, bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int b_hour(int h, bit bin, bit h24);
    int h12;
    if (h24) return b_enc(h, bin);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return b_enc(h12, bin) + ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int b_mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic void m_adv();
    if (ms < 59) begin ms++; return; end
    ms = 0;
    if (mm < 59) begin mm++; return; end
    mm = 0;
    if (mh < 23) begin mh++; return; end
    mh = 0;
    mw = (mw >= 7) ? 1 : mw + 1;
    if (md < b_mlen(mo, my)) begin md++; return; end
    md = 1;
    if (mo < 12) begin mo++; return; end
    mo = 1;
    my = (my >= 99) ? 0 : my + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    addr = a[3:0]; wr_en = 1'b1; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    addr = a[3:0];
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic cmp_reg(int a, int exp, string req);
    int d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  // R1 R6 R7: compare every field in the current format
  task automatic check_all(string req);
    cmp_reg(0, b_enc(ms, fbin), req);
    cmp_reg(2, b_enc(mm, fbin), req);
    cmp_reg(4, b_hour(mh, fbin, fh24), req);
    cmp_reg(6, b_enc(mw, fbin), req);
    cmp_reg(7, b_enc(md, fbin), req);
    cmp_reg(8, b_enc(mo, fbin), req);
    cmp_reg(9, b_enc(my, fbin), req);
  endtask

  function automatic int ctlb_val(bit halt);
    return (halt ? 128 : 0) + (fbin ? 4 : 0) + (fh24 ? 2 : 0);
  endfunction

  task automatic set_mode(bit bin, bit h24);
    fbin = bin; fh24 = h24;
    wr(11, ctlb_val(1'b0));
  endtask

  task automatic load(int s, int m, int h, int w, int dd, int mon, int y);
    ms = s; mm = m; mh = h; mw = w; md = dd; mo = mon; my = y;
    wr(11, ctlb_val(1'b1));
    wr(0, b_enc(ms, fbin));
    wr(2, b_enc(mm, fbin));
    wr(4, b_hour(mh, fbin, fh24));
    wr(6, b_enc(mw, fbin));
    wr(7, b_enc(md, fbin));
    wr(8, b_enc(mo, fbin));
    wr(9, b_enc(my, fbin));
    wr(11, ctlb_val(1'b0));
  endtask

  // R3 R4: one full update cycle with timing checks
  task automatic run_update();
    int cnt = 0;
    int guard = 0;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    while (!upd_done && guard < 1000) begin
      if (uip) cnt++;
      guard++;
      @(negedge clk);
    end
    chk(cnt == LEAD + UPD, "R3 busy length", cnt, LEAD + UPD);
    @(negedge clk);
    chk(upd_done == 1'b0, "R4 pulse width", int'(upd_done), 0);
    m_adv();
  endtask

  task automatic idle_wait(int n, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (uip || upd_done) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int d, k, old;
    bit seen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state: BCD, 12-hour, midnight reads as 12
    fbin = 0; fh24 = 0;
    ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mo = 1; my = 0;
    check_all("R1 reset");
    cmp_reg(11, 0, "R1 reset ctlb");
    cmp_reg(10, 0, "R1 reset ctla");
    wr(10, 8'h7F);
    cmp_reg(10, 8'h7F, "R1 ctla readback");

    // R2 reserved addresses
    wr(1, 8'h55); wr(3, 8'h42); wr(5, 8'h17); wr(13, 8'hFF);
    cmp_reg(1, 0, "R2 reserved 1");
    cmp_reg(3, 0, "R2 reserved 3");
    cmp_reg(5, 0, "R2 reserved 5");
    cmp_reg(13, 0, "R2 reserved 13");
    check_all("R2 fields untouched");

    // R3 lead time seen on the read port
    set_mode(1'b1, 1'b1);
    load(10, 5, 3, 2, 4, 5, 20);
    @(negedge clk);
    addr = 4'd0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(uip == 1'b1, "R3 flag rises", int'(uip), 1);
    old = int'(rd_data);
    k = 0;
    while (int'(rd_data) == old && k < 100) begin @(negedge clk); k++; end
    chk(k == LEAD + 1, "R3 lead cycles", k, LEAD + 1);
    k = 0;
    while (!upd_done && k < 100) begin @(negedge clk); k++; end
    m_adv();
    check_all("R3 advanced");
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd(10, d);
    chk(d[7] == 1'b1, "R3 ctla bit7", d, d | 128);
    k = 0;
    while (!upd_done && k < 100) begin @(negedge clk); k++; end
    m_adv();

    // R5 halt blocks ticks
    wr(11, ctlb_val(1'b1));
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    idle_wait(LEAD + UPD + 8, seen);
    chk(seen == 1'b0, "R5 halt ignores tick", int'(seen), 0);
    wr(11, ctlb_val(1'b0));
    check_all("R5 no advance while halted");
    // R5 halt set during lead abandons the cycle
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wr(11, ctlb_val(1'b1));
    seen = 1'b0;
    for (int i = 0; i < LEAD + UPD + 8; i++) begin
      @(negedge clk);
      if (upd_done) seen = 1'b1;
    end
    chk(seen == 1'b0, "R5 abort no pulse", int'(seen), 0);
    chk(uip == 1'b0, "R5 abort flag low", int'(uip), 0);
    wr(11, ctlb_val(1'b0));
    check_all("R5 abort no advance");

    // R10 year-end cascade, BCD 24-hour
    set_mode(1'b0, 1'b1);
    load(59, 59, 23, 7, 31, 12, 99);
    run_update();
    check_all("R10 year wrap R9 dow wrap");
    // R10 month lengths and February
    load(59, 59, 23, 3, 28, 2, 4);  run_update(); check_all("R10 leap feb 28");
    load(59, 59, 23, 3, 29, 2, 4);  run_update(); check_all("R10 leap feb 29");
    load(59, 59, 23, 3, 28, 2, 3);  run_update(); check_all("R10 plain feb");
    load(59, 59, 23, 3, 30, 4, 50); run_update(); check_all("R10 30-day month");
    load(59, 59, 23, 3, 30, 7, 50); run_update(); check_all("R10 31-day month");
    // R8 R7 12-hour noon and midnight crossings
    set_mode(1'b0, 1'b0);
    load(59, 59, 11, 1, 10, 6, 30); run_update(); check_all("R8 R7 11AM to 12PM");
    load(59, 59, 23, 1, 10, 6, 30); run_update(); check_all("R8 R7 11PM to 12AM");
    set_mode(1'b1, 1'b0);
    load(59, 59, 12, 1, 10, 6, 30); run_update(); check_all("R7 binary 12PM to 1PM");
    // R6 switching format does not alter stored time
    set_mode(1'b1, 1'b1);
    check_all("R6 format switch binary");
    set_mode(1'b0, 1'b1);
    check_all("R6 format switch bcd");

    // random loads in all formats, weighted to rollovers
    for (int it = 0; it < 150; it++) begin
      int s, m, h, w, dd, mon, y, nup;
      set_mode(1'($urandom % 2), 1'($urandom % 2));
      y   = $urandom % 100;
      mon = 1 + $urandom % 12;
      if ($urandom % 2) begin
        s = 59; m = 59; h = ($urandom % 2) ? 23 : 11; dd = b_mlen(mon, y);
      end else begin
        s = $urandom % 60; m = $urandom % 60; h = $urandom % 24;
        dd = 1 + $urandom % b_mlen(mon, y);
      end
      w = 1 + $urandom % 7;
      load(s, m, h, w, dd, mon, y);
      nup = 1 + $urandom % 2;
      for (int u = 0; u < nup; u++) run_update();
      check_all("R6 R7 R8 R9 R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule